// File: doc/BRIEF.md
# Serial-to-Parallel Sample Receiver

This block is the receiving end of a point-to-point serial link that carries fixed-width converter samples. It owns the link timing: it drives a framing strobe (SYNC, active low while bits are being framed) and a serial clock enable that tells the far-end serializer when to present the next bit. Incoming bits are gathered most-significant first into a shift register, and each finished word is copied to a parallel output together with a one-cycle ready pulse.

Two reception styles are offered, selected by a single mode input. In streaming style the framing strobe falls once and words then follow back to back with no gap, one bit per clock. In handshake style every word is framed on its own: the strobe is low for the first N-1 bits, rises for the final bit, the word is loaded, and the controller passes through a ready-announce state before framing the next word. The mode input is only consulted where a word boundary is guaranteed, so a word is never split between the two styles.

Top module: `s2p_sample_rx`

## Requirements
- R1: While reset is held, SYNC is high, the serial clock enable is low, the ready pulse is low and the parallel word is all zeros.
- R2: After reset is released the controller spends exactly one clock in power-up and one clock deciding the mode; the serial clock enable first rises after the 2nd clock edge in streaming mode (mode input high) and after the 3rd edge in handshake mode (mode input low).
- R3: In streaming mode SYNC stays low and the serial clock enable stays high across word boundaries, and ready pulses arrive exactly N clocks apart.
- R4: The first bit received for a word becomes bit N-1 of the parallel word and the last becomes bit 0; each completed word produces exactly one ready pulse of one clock, and no pulse is produced for a partial word.
- R5: The parallel word changes only in a cycle where ready is high and otherwise holds its value.
- R6: In handshake mode SYNC is low for the first N-1 enabled clocks of a word and high for the N-th; ready pulses arrive N+2 clocks apart, and during each pulse SYNC is high and the serial clock enable is low.
- R7: When the mode input drops during streaming, the word in progress is completed in streaming form and the ready pulse for it is issued in the ready-announce state (SYNC high, enable low).
- R8: Changes of the mode input in the middle of a word have no effect on that word or on the mode of following words once restored before the word ends.
- R9: When the mode input rises during a handshake word, that word still finishes with SYNC high on its last bit, and reception then continues in streaming form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all bits are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sdi_i | input | 1 | Serial data from the serializer, valid when the enable is high |
| stream_i | input | 1 | Mode select: 1 streaming, 0 per-word handshake |
| sync_o | output | 1 | Framing strobe to the serializer, low while bits are framed |
| sclk_en_o | output | 1 | Serial clock enable; one bit is taken on each edge it is high |
| word_o | output | N | Last completed word, MSB received first |
| rdy_o | output | 1 | One-clock pulse marking a newly loaded word |

## Verification
The bench models the serializer from the enable and strobe alone and scores every ready pulse against the words it sent, so a receiver that shifted LSB first, counted one bit too few or pulsed ready for a cut-off word after reset would show a word mismatch or an unexpected pulse. Mode changes are driven both at word boundaries and in the middle of words: a controller that sampled the mode every clock would split a word and break the N or N+2 clock spacing of ready pulses, and one that skipped the extra shift with SYNC high would show the strobe low on the final bit. Reset is applied twice, once in each mode, to catch a power-up state that lingers or is skipped, which moves the first enable edge away from the 2nd or 3rd clock.

// File: rtl/s2p_rx_pkg.sv
package s2p_rx_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP = 3'd0,
      ST_MSEL  = 3'd1,
      ST_STRM  = 3'd2,
      ST_WAIT  = 3'd3,
      ST_SHIFT = 3'd4,
      ST_EXTRA = 3'd5,
      ST_LOAD  = 3'd6
   } rx_state_e;

endpackage

// File: rtl/s2p_rx_bitcnt.sv
module s2p_rx_bitcnt #(
   parameter int N = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o,
   output logic prelast_o
);
   localparam int CW = (N > 2) ? $clog2(N) : 1;

   generate
      if (N < 2) begin : g_bad_width
         $error("s2p_rx_bitcnt: N must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + CW'(1);
   end

   assign last_o    = (cnt_q == CW'(N - 1));
   assign prelast_o = (cnt_q == CW'(N - 2));

endmodule

// File: rtl/s2p_rx_shreg.sv
module s2p_rx_shreg #(
   parameter int N = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic         sdi_i,
   output logic [N-1:0] q_o,
   output logic [N-1:0] next_o
);
   logic [N-1:0] sh_q;

   // MSB-first: new bits enter at bit 0 and move upward
   generate
      for (genvar i = 0; i < N; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign next_o[i] = sdi_i;
         end else begin : g_body
            assign next_o[i] = sh_q[i-1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n)     sh_q[i] <= 1'b0;
            else if (en_i)  sh_q[i] <= next_o[i];
         end
      end
   endgenerate

   assign q_o = sh_q;

endmodule

// File: rtl/s2p_rx_hold.sv
module s2p_rx_hold #(
   parameter int N = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] word_o,
   output logic         rdy_o
);
   logic [N-1:0] word_q;
   logic         rdy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         rdy_q  <= 1'b0;
      end else begin
         rdy_q <= ld_i;
         if (ld_i) word_q <= d_i;
      end
   end

   assign word_o = word_q;
   assign rdy_o  = rdy_q;

   // R4
   rdy_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q |=> !rdy_q);

endmodule

// File: rtl/s2p_rx_fsm.sv
module s2p_rx_fsm
   import s2p_rx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stream_i,
   input  logic cnt_last_i,
   input  logic cnt_prelast_i,
   output logic sync_o,
   output logic shift_en_o,
   output logic cnt_clr_o,
   output logic ld_stream_o,
   output logic ld_frame_o
);
   rx_state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_PWRUP;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_PWRUP: state_d = ST_MSEL;
         ST_MSEL:  state_d = stream_i ? ST_STRM : ST_WAIT;
         ST_STRM:  if (cnt_last_i && !stream_i) state_d = ST_WAIT;
         ST_WAIT:  state_d = stream_i ? ST_STRM : ST_SHIFT;
         ST_SHIFT: if (cnt_prelast_i) state_d = ST_EXTRA;
         ST_EXTRA: state_d = ST_LOAD;
         ST_LOAD:  state_d = ST_WAIT;
         default:  state_d = ST_PWRUP;
      endcase
   end

   logic in_strm, in_shift, in_extra;
   assign in_strm  = (state_q == ST_STRM);
   assign in_shift = (state_q == ST_SHIFT);
   assign in_extra = (state_q == ST_EXTRA);

   assign sync_o      = !(in_strm || in_shift);
   assign shift_en_o  = in_strm || in_shift || in_extra;
   assign ld_stream_o = in_strm && cnt_last_i;
   assign ld_frame_o  = (state_q == ST_LOAD);
   assign cnt_clr_o   = !(in_strm || in_shift) || ld_stream_o;

   // R2
   pwrup_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PWRUP) |=> (state_q == ST_MSEL));

   // R8
   strm_midword_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_strm && !cnt_last_i) |=> (state_q == ST_STRM));

   // R7
   strm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_strm && cnt_last_i && !stream_i) |=> (state_q == ST_WAIT));

   // R6
   extra_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_extra |-> cnt_last_i);

endmodule

// File: rtl/s2p_sample_rx.sv
module s2p_sample_rx #(
   parameter int N = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sdi_i,
   input  logic         stream_i,
   output logic         sync_o,
   output logic         sclk_en_o,
   output logic [N-1:0] word_o,
   output logic         rdy_o
);
   generate
      if (N < 2) begin : g_bad_width
         $error("s2p_sample_rx: N must be at least 2");
      end
   endgenerate

   logic         shift_en, cnt_clr, cnt_last, cnt_prelast;
   logic         ld_stream, ld_frame;
   logic [N-1:0] sh_q, sh_next, word_d;

   s2p_rx_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .stream_i      (stream_i),
      .cnt_last_i    (cnt_last),
      .cnt_prelast_i (cnt_prelast),
      .sync_o        (sync_o),
      .shift_en_o    (shift_en),
      .cnt_clr_o     (cnt_clr),
      .ld_stream_o   (ld_stream),
      .ld_frame_o    (ld_frame)
   );

   s2p_rx_bitcnt #(.N(N)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (cnt_clr),
      .inc_i     (shift_en),
      .last_o    (cnt_last),
      .prelast_o (cnt_prelast)
   );

   s2p_rx_shreg #(.N(N)) u_sh (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (shift_en),
      .sdi_i  (sdi_i),
      .q_o    (sh_q),
      .next_o (sh_next)
   );

   // streaming completes on the edge that takes the last bit
   assign word_d = ld_stream ? sh_next : sh_q;

   s2p_rx_hold #(.N(N)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_i   (ld_stream || ld_frame),
      .d_i    (word_d),
      .word_o (word_o),
      .rdy_o  (rdy_o)
   );

   assign sclk_en_o = shift_en;

   // R5
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_o |-> (word_o == $past(word_o)));

endmodule

// File: tb/sim_s2p_sample_rx.sv
module sim_s2p_sample_rx;
   localparam int N = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sdi = 1'b0;
   logic stream = 1'b1;
   logic sync, sclk_en, rdy;
   logic [N-1:0] word;

   s2p_sample_rx #(.N(N)) u0 (
      .clk(clk), .rst_n(rst_n), .sdi_i(sdi), .stream_i(stream),
      .sync_o(sync), .sclk_en_o(sclk_en), .word_o(word), .rdy_o(rdy)
   );

   always #10 clk = ~clk;

   int total = 0, bad = 0;
   logic [N-1:0] expq[$];
   logic [N-1:0] cur = {N{1'b1}};
   logic [15:0]  lfsr = 16'hACE1;
   int bitpos = 0, cyc = 0, last_rdy = -1, iv_exp = 0, rdy_state_exp = 0;
   int nth_hi = 0, nth_lo = 0, rdy_cnt = 0, wcount = 0;
   logic [N-1:0] prev_word = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] gen_word();
      logic [15:0] x;
      wcount++;
      if (wcount == 1) return '0;
      if (wcount == 2) return {N/2{2'b10}};
      x = lfsr;
      x ^= x << 7; x ^= x >> 9; x ^= x << 8;
      lfsr = x;
      return x[N-1:0];
   endfunction

   always @(posedge clk) cyc++;

   // scoreboard monitor followed by serializer model
   always @(negedge clk) begin
      if (rst_n) begin
         if (rdy) begin
            rdy_cnt++;
            if (expq.size() == 0) chk(1'b0, "R4 ready without a full word", int'(word), -1);
            else begin
               logic [N-1:0] e;
               e = expq.pop_front();
               chk(word == e, "R4 word assembled MSB first", int'(word), int'(e));
            end
            if (iv_exp != 0 && last_rdy >= 0)
               chk(cyc - last_rdy == iv_exp, (iv_exp == N) ? "R3 ready spacing" : "R6 ready spacing",
                   cyc - last_rdy, iv_exp);
            last_rdy = cyc;
            if (rdy_state_exp == 1)
               chk(sclk_en && !sync, "R3 stream continues at word end", {sclk_en, sync}, 2);
            else if (rdy_state_exp == 2)
               chk(!sclk_en && sync, "R7 ready in announce state", {sclk_en, sync}, 1);
         end else begin
            chk(word == prev_word, "R5 word holds without ready", int'(word), int'(prev_word));
         end
         prev_word = word;
         if (sclk_en) begin
            if (bitpos < N-1) chk(!sync, "R6 sync low on leading bits", sync, 0);
            else if (sync) nth_hi++;
            else nth_lo++;
            sdi = cur[N-1-bitpos];
            if (bitpos == N-1) begin
               expq.push_back(cur);
               cur = gen_word();
               bitpos = 0;
            end else bitpos++;
         end
      end else begin
         bitpos = 0;
         expq.delete();
         prev_word = '0;
      end
   end

   task automatic wait_rdy(input int k);
      int t;
      t = rdy_cnt + k;
      while (rdy_cnt < t) @(posedge clk);
      #2;
   endtask

   task automatic wait_bit(input int p);
      do begin @(posedge clk); #2; end while (!(sclk_en && bitpos == p));
   endtask

   task automatic reset_and_start(input bit mode, input int exp_edges);
      int n;
      stream = mode;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      chk(sync == 1'b1, "R1 sync high in reset", sync, 1);
      chk(sclk_en == 1'b0, "R1 enable low in reset", sclk_en, 0);
      chk(rdy == 1'b0, "R1 ready low in reset", rdy, 0);
      chk(word == '0, "R1 word cleared in reset", int'(word), 0);
      rst_n = 1'b1;
      n = 0;
      do begin @(posedge clk); n++; #2; end while (!sclk_en && n < 10);
      chk(n == exp_edges, "R2 first enable edge after reset", n, exp_edges);
   endtask

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired R3 actual=%0d expected=%0d", cyc, 0);
      finish_up();
   end

   initial begin
      // streaming start
      reset_and_start(1'b1, 2);
      iv_exp = N; last_rdy = -1; rdy_state_exp = 1; nth_hi = 0; nth_lo = 0;
      wait_rdy(5);
      chk(nth_hi == 0, "R3 sync never rises in streaming", nth_hi, 0);

      // R8: mode glitch in the middle of a streaming word
      wait_bit(3);
      stream = 1'b0;
      repeat (4) @(posedge clk);
      #2 stream = 1'b1;
      wait_rdy(4);
      chk(nth_hi == 0, "R8 mid-word mode change ignored in streaming", nth_hi, 0);

      // R7: drop to handshake mid-word
      wait_bit(5);
      stream = 1'b0;
      rdy_state_exp = 2; iv_exp = N + 2; last_rdy = -1;
      wait_rdy(1);
      chk(nth_lo >= 1, "R7 last streaming word finished with sync low", nth_lo, 1);
      nth_hi = 0; nth_lo = 0;
      wait_rdy(5);
      chk(nth_hi == 5 && nth_lo == 0, "R6 extra shift with sync high", nth_hi, 5);

      // R8: mode glitch in the middle of a handshake word
      wait_bit(3);
      stream = 1'b1;
      repeat (4) @(posedge clk);
      #2 stream = 1'b0;
      wait_rdy(3);
      chk(nth_lo == 0, "R8 mid-word mode change ignored in handshake", nth_lo, 0);

      // R9: rise to streaming during a handshake word
      nth_hi = 0; nth_lo = 0;
      wait_bit(4);
      stream = 1'b1;
      wait_rdy(1);
      chk(nth_hi == 1 && nth_lo == 0, "R9 framed word finished with sync high", nth_hi, 1);
      rdy_state_exp = 1; iv_exp = N; last_rdy = -1; nth_hi = 0; nth_lo = 0;
      wait_rdy(4);
      chk(nth_hi == 0 && nth_lo >= 4, "R9 streaming resumed", nth_lo, 4);

      // reset mid-word, restart in handshake mode
      wait_bit(6);
      rdy_state_exp = 0; iv_exp = 0;
      reset_and_start(1'b0, 3);
      rdy_state_exp = 2; iv_exp = N + 2; last_rdy = -1; nth_hi = 0; nth_lo = 0;
      wait_rdy(3);
      chk(nth_hi == 3 && nth_lo == 0, "R6 handshake after reset", nth_hi, 3);
      chk(expq.size() == 0, "R4 every sent word scored", expq.size(), 0);

      finish_up();
   end

endmodule